// File: doc/BRIEF.md
# External Bus Strobe Phase Timer

This block sequences the control strobes of one access on an asynchronous external memory or peripheral bus. An access request names a zone and says whether it is a read or a write. The block then runs three phases in timing-clock cycles. The first is an address-setup (lead) phase. The second is a strobe (active) phase. The last is a hold (trail) phase. It drives chip-select, the read or write strobe, and a one-cycle completion pulse.

Each zone holds its own timing set, loaded through a small write port. The set has separate lead, active and trail counts for reads and for writes. It also has a doubling option and a choice of whether the external ready input may stretch the strobe. The block executes whatever counts are programmed and does not reject small or unusual settings. The timing set is captured when the request is accepted, so a reload never disturbs an access already in progress.

Top module: `bus_phase_timer`

## Requirements
- R1: After reset, cs_o, rd_o, wr_o and done_o are low and req_ready_o is high.
- R2: A write with cfg_we_i high stores cfg_data_i into zone cfg_zone_i. The bit fields are: read lead [1:0], read active [4:2], read trail [6:5], write lead [8:7], write active [11:9], write trail [13:12], doubling [14], use-ready [15]. After reset every zone holds all zeros.
- R3: The lead phase lasts the selected lead count in cycles, or twice that count with doubling. cs_o rises in the first cycle after the accepting clock edge.
- R4: The active phase lasts the selected active count (doubled when doubling is set) plus the wait cycles plus one. rd_o is high only in the active phase of a read, and wr_o is high only in the active phase of a write.
- R5: The trail phase lasts the selected trail count, or twice that count with doubling. cs_o stays high through the last trail cycle.
- R6: Reads use the read fields and writes use the write fields of the addressed zone.
- R7: With use-ready set, rdy_i is sampled only after the scaled active count has expired. Each sampled low cycle adds one wait cycle, and a low rdy_i before expiry has no effect.
- R8: With use-ready clear, rdy_i is ignored and no wait cycles are added.
- R9: done_o is high for exactly one cycle, the cycle right after the last trail cycle, with cs_o low.
- R10: A request is accepted only while req_ready_o is high. A request presented during an access is dropped and starts nothing.
- R11: A configuration write during an access does not change that access. It applies from the next access on.
- R12: A lead or trail count of zero gives a phase of zero length.
- R13: Doubling scales only the programmed counts, not the fixed extra active cycle or the ready wait cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Timing clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write enable |
| cfg_zone_i | input | ZONE_W | Zone to configure |
| cfg_data_i | input | CFG_W | Packed zone timing set |
| req_valid_i | input | 1 | Access request |
| req_zone_i | input | ZONE_W | Zone of the request |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_ready_o | output | 1 | Sequencer idle, request accepted |
| rdy_i | input | 1 | External ready, synchronous to clk_i |
| cs_o | output | 1 | Chip-select, active high |
| rd_o | output | 1 | Read strobe, active high |
| wr_o | output | 1 | Write strobe, active high |
| done_o | output | 1 | Access complete pulse |

## Verification
Cycle k is counted from the clock edge that accepts the request, with k=1 the first cycle after that edge. With scaled counts L, A, T and W wait cycles, the first strobe cycle is k=L+1, the strobe lasts A+W+1 cycles, cs_o lasts L+A+W+1+T cycles, and done_o is due at k=L+A+W+T+2. The bench samples every output on the falling edge of each cycle k and compares the counted lengths and positions with these formulas. It drives rdy_i on the falling edge of cycle k, so the value is the one the design samples at the end of that cycle. Ready stays low from the start of the access until cycle L+A+1+W, which also shows that low ready before expiry is ignored.

// File: rtl/bpt_pkg.sv
package bpt_pkg;
  parameter int unsigned LEAD_W  = 2;
  parameter int unsigned ACT_W   = 3;
  parameter int unsigned TRAIL_W = 2;

  localparam int unsigned MAX_W = (ACT_W > LEAD_W)
                                  ? ((ACT_W > TRAIL_W) ? ACT_W : TRAIL_W)
                                  : ((LEAD_W > TRAIL_W) ? LEAD_W : TRAIL_W);
  // doubled field fits in one extra bit
  localparam int unsigned CNT_W = MAX_W + 1;

  typedef struct packed {
    logic               use_rdy;
    logic               dbl;
    logic [TRAIL_W-1:0] wr_trail;
    logic [ACT_W-1:0]   wr_act;
    logic [LEAD_W-1:0]  wr_lead;
    logic [TRAIL_W-1:0] rd_trail;
    logic [ACT_W-1:0]   rd_act;
    logic [LEAD_W-1:0]  rd_lead;
  } zone_cfg_t;

  localparam int unsigned CFG_W = $bits(zone_cfg_t);

  typedef struct packed {
    logic [CNT_W-1:0] lead;
    logic [CNT_W-1:0] act;
    logic [CNT_W-1:0] trail;
    logic             use_rdy;
    logic             write;
  } acc_plan_t;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_ACT   = 3'd2,
    ST_TRAIL = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_e;
endpackage

// File: rtl/bpt_cfg_regs.sv
module bpt_cfg_regs
  import bpt_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4,
  parameter int unsigned ZONE_W    = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ZONE_W-1:0] wzone_i,
  input  zone_cfg_t         wdata_i,
  input  logic [ZONE_W-1:0] rzone_i,
  output zone_cfg_t         rdata_o
);
  zone_cfg_t cfg_q [NUM_ZONES];

  for (genvar z = 0; z < NUM_ZONES; z++) begin : g_zone
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cfg_q[z] <= '0;
      end else if (we_i && (32'(wzone_i) == z)) begin
        cfg_q[z] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int z = 0; z < NUM_ZONES; z++) begin
      if (32'(rzone_i) == z) rdata_o = cfg_q[z];
    end
  end
endmodule

// File: rtl/bpt_phase_calc.sv
module bpt_phase_calc
  import bpt_pkg::*;
(
  input  zone_cfg_t cfg_i,
  input  logic      write_i,
  output acc_plan_t plan_o
);
  function automatic logic [CNT_W-1:0] scale(input logic [CNT_W-1:0] v, input logic d);
    return d ? (v << 1) : v;
  endfunction

  logic [CNT_W-1:0] lead_raw, act_raw, trail_raw;

  always_comb begin
    if (write_i) begin
      lead_raw  = CNT_W'(cfg_i.wr_lead);
      act_raw   = CNT_W'(cfg_i.wr_act);
      trail_raw = CNT_W'(cfg_i.wr_trail);
    end else begin
      lead_raw  = CNT_W'(cfg_i.rd_lead);
      act_raw   = CNT_W'(cfg_i.rd_act);
      trail_raw = CNT_W'(cfg_i.rd_trail);
    end
    plan_o.lead    = scale(lead_raw, cfg_i.dbl);
    plan_o.act     = scale(act_raw, cfg_i.dbl);
    plan_o.trail   = scale(trail_raw, cfg_i.dbl);
    plan_o.use_rdy = cfg_i.use_rdy;
    plan_o.write   = write_i;
  end
endmodule

// File: rtl/bpt_seq.sv
module bpt_seq
  import bpt_pkg::*;
(
  input  logic      clk_i,
  input  logic      rst_ni,
  input  logic      req_valid_i,
  input  acc_plan_t plan_i,
  input  logic      rdy_i,
  output logic      idle_o,
  output logic      cs_o,
  output logic      rd_o,
  output logic      wr_o,
  output logic      done_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  seq_state_e       state_q;
  logic [CNT_W-1:0] cnt_q;
  acc_plan_t        plan_q;
  logic             act_go;

  // past the programmed count, leave unless ready holds us
  assign act_go = (cnt_q == '0) && (!plan_q.use_rdy || rdy_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      plan_q  <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            plan_q <= plan_i;
            if (plan_i.lead != '0) begin
              state_q <= ST_LEAD;
              cnt_q   <= plan_i.lead - ONE;
            end else begin
              state_q <= ST_ACT;
              cnt_q   <= plan_i.act;
            end
          end
        end
        ST_LEAD: begin
          if (cnt_q == '0) begin
            state_q <= ST_ACT;
            cnt_q   <= plan_q.act;
          end else begin
            cnt_q <= cnt_q - ONE;
          end
        end
        ST_ACT: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
          end else if (act_go) begin
            if (plan_q.trail != '0) begin
              state_q <= ST_TRAIL;
              cnt_q   <= plan_q.trail - ONE;
            end else begin
              state_q <= ST_DONE;
            end
          end
        end
        ST_TRAIL: begin
          if (cnt_q == '0) state_q <= ST_DONE;
          else             cnt_q   <= cnt_q - ONE;
        end
        ST_DONE: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign cs_o   = (state_q == ST_LEAD) || (state_q == ST_ACT) || (state_q == ST_TRAIL);
  assign rd_o   = (state_q == ST_ACT) && !plan_q.write;
  assign wr_o   = (state_q == ST_ACT) &&  plan_q.write;
  assign done_o = (state_q == ST_DONE);
endmodule

// File: rtl/bus_phase_timer.sv
module bus_phase_timer
  import bpt_pkg::*;
#(
  parameter int unsigned NUM_ZONES = 4,
  parameter int unsigned ZONE_W    = (NUM_ZONES > 1) ? $clog2(NUM_ZONES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_we_i,
  input  logic [ZONE_W-1:0] cfg_zone_i,
  input  logic [CFG_W-1:0]  cfg_data_i,
  input  logic              req_valid_i,
  input  logic [ZONE_W-1:0] req_zone_i,
  input  logic              req_write_i,
  output logic              req_ready_o,
  input  logic              rdy_i,
  output logic              cs_o,
  output logic              rd_o,
  output logic              wr_o,
  output logic              done_o
);
  zone_cfg_t sel_cfg;
  acc_plan_t plan;

  bpt_cfg_regs #(
    .NUM_ZONES (NUM_ZONES),
    .ZONE_W    (ZONE_W)
  ) u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (cfg_we_i),
    .wzone_i (cfg_zone_i),
    .wdata_i (zone_cfg_t'(cfg_data_i)),
    .rzone_i (req_zone_i),
    .rdata_o (sel_cfg)
  );

  bpt_phase_calc u_calc (
    .cfg_i   (sel_cfg),
    .write_i (req_write_i),
    .plan_o  (plan)
  );

  bpt_seq u_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_valid_i (req_valid_i),
    .plan_i      (plan),
    .rdy_i       (rdy_i),
    .idle_o      (req_ready_o),
    .cs_o        (cs_o),
    .rd_o        (rd_o),
    .wr_o        (wr_o),
    .done_o      (done_o)
  );
endmodule

// File: rtl/bpt_chk.sv
module bpt_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic req_ready_o,
  input logic cs_o,
  input logic rd_o,
  input logic wr_o,
  input logic done_o
);
  // R4
  strobe_in_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o || wr_o) |-> cs_o);

  // R4
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_o && wr_o));

  // R9
  done_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R9
  done_after_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_o) |-> done_o);

  // R9
  done_no_cs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !cs_o);

  // R10
  busy_not_ready_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_o || done_o) |-> !req_ready_o);

  // R4
  strobe_kind_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_o && $past(rd_o || wr_o)) |-> $past(rd_o));
endmodule

bind bus_phase_timer bpt_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_ready_o (req_ready_o),
  .cs_o        (cs_o),
  .rd_o        (rd_o),
  .wr_o        (wr_o),
  .done_o      (done_o)
);

// File: tb/tb_bus_phase_timer.sv
`timescale 1ns/1ps
module tb_bus_phase_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_zone = '0;
  logic [15:0] cfg_data = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_zone = '0;
  logic        req_write = 1'b0;
  logic        req_ready;
  logic        rdy = 1'b1;
  logic        cs, rd, wr, done;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;
  logic [15:0] model [4];

  always #2.5 clk = ~clk;

  bus_phase_timer dut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_zone_i(cfg_zone), .cfg_data_i(cfg_data),
    .req_valid_i(req_valid), .req_zone_i(req_zone), .req_write_i(req_write),
    .req_ready_o(req_ready), .rdy_i(rdy),
    .cs_o(cs), .rd_o(rd), .wr_o(wr), .done_o(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // bit fields per R2
  function automatic logic [15:0] pack(input int rl, ra, rt, wl, wa, wt, input bit dbl, ur);
    return {ur, dbl, 2'(wt), 3'(wa), 2'(wl), 2'(rt), 3'(ra), 2'(rl)};
  endfunction

  task automatic cfg_write(input int z, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_zone = 2'(z); cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
    model[z] = d;
  endtask

  // One access; w = cycles ready stays low after the active count expires.
  task automatic do_access(input int z, input bit wrt, input int w, input bit mid_we,
                           input logic [15:0] mid_data, input bit poke, input string tag);
    logic [15:0] d = model[z];
    bit dbl = d[14];
    bit ur  = d[15];
    int l = wrt ? int'(d[8:7])   : int'(d[1:0]);
    int a = wrt ? int'(d[11:9])  : int'(d[4:2]);
    int t = wrt ? int'(d[13:12]) : int'(d[6:5]);
    int ls, as, ts, ws, fin;
    int cs_n = 0, stb_n = 0, bad_n = 0, first_stb = -1, done_at = -1;
    ls = dbl ? 2*l : l;
    as = dbl ? 2*a : a;
    ts = dbl ? 2*t : t;
    ws = ur ? w : 0;
    fin = ls + as + 1;
    @(negedge clk);
    chk(req_ready == 1'b1, {tag, " R10 idle before request"}, int'(req_ready), 1);
    req_valid = 1'b1; req_zone = 2'(z); req_write = wrt; rdy = 1'b0;
    for (int i = 1; i <= 100; i++) begin
      @(negedge clk);
      if (i == 1) req_valid = 1'b0;
      if (cs) cs_n++;
      if (rd || wr) begin
        stb_n++;
        if (first_stb < 0) first_stb = i;
      end
      if ((wrt && rd) || (!wrt && wr)) bad_n++;
      if (done) begin
        done_at = i;
        break;
      end
      rdy = (i >= fin + w);
      if (mid_we && i == 2) begin cfg_we = 1'b1; cfg_zone = 2'(z); cfg_data = mid_data; end
      if (i == 3) cfg_we = 1'b0;
      if (poke && i == 2) begin req_valid = 1'b1; req_zone = 2'(z ^ 1); req_write = ~wrt; end
      if (poke && i == 3) req_valid = 1'b0;
    end
    rdy = 1'b1;
    chk(first_stb == ls + 1, {tag, " R3 lead length"}, first_stb - 1, ls);
    chk(stb_n == as + ws + 1, {tag, " R4 active length"}, stb_n, as + ws + 1);
    chk(cs_n == ls + as + ws + 1 + ts, {tag, " R5 cs length"}, cs_n, ls + as + ws + 1 + ts);
    chk(bad_n == 0, {tag, " R6 strobe kind"}, bad_n, 0);
    chk(done_at == ls + as + ws + ts + 2, {tag, " R9 done cycle"}, done_at, ls + as + ws + ts + 2);
    @(negedge clk);
    chk(done == 1'b0 && cs == 1'b0, {tag, " R9 done single"}, int'(done), 0);
    if (mid_we) model[z] = mid_data;
    if (poke) begin
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        chk(cs == 1'b0 && req_ready == 1'b1, {tag, " R10 busy request dropped"}, int'(cs), 0);
      end
    end
  endtask

  task automatic t_reset;
    chk(cs == 0 && rd == 0 && wr == 0 && done == 0, "R1 outputs idle", int'({cs, rd, wr, done}), 0);
    chk(req_ready == 1'b1, "R1 ready high", int'(req_ready), 1);
  endtask

  task automatic t_default_cfg;
    // R2 reset config all zero, R12 zero lead/trail
    do_access(1, 1'b0, 2, 1'b0, '0, 1'b0, "R2 R12 default zone");
  endtask

  task automatic t_basic_read_write;
    cfg_write(0, pack(2, 3, 1, 1, 5, 2, 1'b0, 1'b0));
    do_access(0, 1'b0, 3, 1'b0, '0, 1'b0, "R8 read ignore ready");
    do_access(0, 1'b1, 2, 1'b0, '0, 1'b0, "R6 write fields");
  endtask

  task automatic t_double_ready;
    cfg_write(2, pack(3, 2, 2, 0, 1, 3, 1'b1, 1'b1));
    do_access(2, 1'b0, 2, 1'b0, '0, 1'b0, "R13 R7 doubled read");
    do_access(2, 1'b1, 3, 1'b0, '0, 1'b0, "R13 R12 doubled write");
  endtask

  task automatic t_ready_waits;
    cfg_write(3, pack(1, 2, 1, 0, 0, 0, 1'b0, 1'b1));
    do_access(3, 1'b0, 0, 1'b0, '0, 1'b0, "R7 no wait");
    do_access(3, 1'b0, 4, 1'b0, '0, 1'b0, "R7 four waits");
    do_access(3, 1'b1, 1, 1'b0, '0, 1'b0, "R7 R12 zero write");
  endtask

  task automatic t_mid_change;
    do_access(0, 1'b0, 0, 1'b1, pack(0, 1, 3, 1, 5, 2, 1'b0, 1'b0), 1'b1, "R11 R10 mid change");
    do_access(0, 1'b0, 0, 1'b0, '0, 1'b0, "R11 new config");
  endtask

  initial begin
    for (int z = 0; z < 4; z++) model[z] = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_default_cfg();
    t_basic_read_write();
    t_double_ready();
    t_ready_waits();
    t_mid_change();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule